// File: doc/BRIEF.md
# Power-Mode Clock Divider

This block derives a slower clock-enable from a fast infrastructure clock. The division ratio is chosen from a small, non-linear set: 1, 2, 8 or 32. Each power state has its own setting. There are three 2-bit setting registers, one each for the run, sleep and deep-sleep states. A register bus writes them and reads them back.

A live power-state input selects the register in force. The block emits a single-cycle enable pulse once every N input clocks, where N is the ratio of that register. Downstream logic qualifies its flops with this pulse instead of using a second clock tree.

A new ratio, whether it comes from a register write or a change of power state, is taken up only at a pulse boundary. Every interval between two pulses is therefore a whole period of one ratio. A ratio change never produces a runt interval.

Top module: `pmode_clk_div`

## Requirements
- R1: Setting code 0 gives a ratio of 1, code 1 a ratio of 2, code 2 a ratio of 8 and code 3 a ratio of 32. The enable pulse `tick_o` is high for exactly one cycle in every N cycles.
- R2: The power-state input `mode_i` selects the register in force: 0 selects run, 1 selects sleep, 2 selects deep sleep.
- R3: A write with `wr_en_i` high and `wr_sel_i` in 0..2 stores `wr_data_i` into that register at the clock edge. `rd_data_o` combinationally returns the stored code of the register named by `rd_sel_i`.
- R4: A write with `wr_sel_i` = 3 changes no register. Reading with `rd_sel_i` = 3 returns 0.
- R5: While the ratio in force is 1, `tick_o` is high in every cycle.
- R6: The ratio in force is sampled only in a cycle where `tick_o` is high. The next pulse follows exactly that ratio's number of cycles later, whatever writes or power-state changes happen in between.
- R7: While `mode_i` = 3 (not a valid state), the register of the last valid power state stays selected. Before any valid state has been seen, that is run.
- R8: After reset all three registers hold code 0, the ratio in force is 1, and `tick_o` is high in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Infrastructure clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Live power state: 0 run, 1 sleep, 2 deep sleep, 3 invalid |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selected for the write |
| wr_data_i | input | 2 | Setting code to write |
| rd_sel_i | input | 2 | Register selected for readback |
| rd_data_o | output | 2 | Stored code of the selected register |
| tick_o | output | 1 | One-cycle clock-enable pulse, once every N cycles |

## Verification
The bench targets three kinds of change made partway through a period: a register rewrite, a power-state switch and a step into the invalid state. If a design restarted its counter at once, it would emit a short interval. If it ignored the held state, it would jump to the wrong register.

The bench also covers the following cases:
- A write to select 3. A design that aliased it onto another register would show a changed readback.
- Divide-by-1 right after reset. A counter that needs one idle cycle would drop the first pulses.
- The longest ratio of 32. A counter that is too narrow would wrap early.

// File: rtl/pmcd_pkg.sv
package pmcd_pkg;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned CNT_W  = 5;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_DEEP  = 2'd2,
    PM_NONE  = 2'd3
  } pm_state_t;

  // Terminal count (ratio minus one) for a setting code.
  function automatic logic [CNT_W-1:0] code_to_limit(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    code_to_limit = CNT_W'(0);
      2'd1:    code_to_limit = CNT_W'(1);
      2'd2:    code_to_limit = CNT_W'(7);
      default: code_to_limit = CNT_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/pmcd_regs.sv
module pmcd_regs
  import pmcd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [1:0]        use_sel_i,
  output logic [CODE_W-1:0] rd_data_o,
  output logic [CODE_W-1:0] use_code_o
);
  logic [CODE_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en_i && (wr_sel_i == 2'(g)))
        regs_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o  = '0;
    use_code_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel_i == 2'(i))  rd_data_o  = regs_q[i];
      if (use_sel_i == 2'(i)) use_code_o = regs_q[i];
    end
  end

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i < 2'(NUM_REGS)) |=> (regs_q[$past(wr_sel_i)] == $past(wr_data_i)));

  p_bad_sel_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd3) |=>
      ($stable(regs_q[0]) && $stable(regs_q[1]) && $stable(regs_q[2])));
endmodule

// File: rtl/pmcd_mode_sel.sv
module pmcd_mode_sel
  import pmcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  output logic [1:0] eff_sel_o
);
  logic [1:0] last_q;
  logic       valid;

  assign valid     = (mode_i != PM_NONE);
  assign eff_sel_o = valid ? mode_i : last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= PM_RUN;
    else if (valid) last_q <= mode_i;
  end

  p_hold_on_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PM_NONE) |=> (mode_i == PM_NONE) |-> $stable(eff_sel_o));

  p_sel_is_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eff_sel_o != PM_NONE);
endmodule

// File: rtl/pmcd_tick_gen.sv
module pmcd_tick_gen
  import pmcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] req_code_i,
  output logic              tick_o
);
  logic [CODE_W-1:0] active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;

  assign limit  = code_to_limit(active_q);
  assign tick_o = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      cnt_q    <= '0;
    end else if (tick_o) begin
      active_q <= req_code_i;
      cnt_q    <= '0;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  p_div1_every_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == '0) |-> tick_o);

  p_ratio_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(active_q));

  p_restart_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/pmode_clk_div.sv
module pmode_clk_div
  import pmcd_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [1:0] wr_data_i,
  input  logic [1:0] rd_sel_i,
  output logic [1:0] rd_data_o,
  output logic       tick_o
);
  logic [1:0]        eff_sel;
  logic [CODE_W-1:0] use_code;

  pmcd_mode_sel i_mode_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .eff_sel_o (eff_sel)
  );

  pmcd_regs #(.NUM_REGS(NUM_REGS)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .rd_sel_i   (rd_sel_i),
    .use_sel_i  (eff_sel),
    .rd_data_o  (rd_data_o),
    .use_code_o (use_code)
  );

  pmcd_tick_gen i_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_code_i (use_code),
    .tick_o     (tick_o)
  );

  p_reset_tick_r8: assert property (@(posedge clk)
    !rst_n |=> tick_o);
endmodule

// File: tb/test_pmode_clk_div.sv
module test_pmode_clk_div;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i, wr_sel_i, wr_data_i, rd_sel_i, rd_data_o;
  logic       wr_en_i, tick_o;

  int total = 0;
  int bad   = 0;

  // Bench model of the register file and pulse timing, built from R1..R8.
  logic [1:0] m_regs [3];
  logic [1:0] m_last;
  logic [1:0] m_active;
  int         m_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmode_clk_div i_pmode_clk_div (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .tick_o(tick_o)
  );

  function automatic int ratio_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 32;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check, then advance the model across the edge.
  task automatic step(input string req, input logic [1:0] md, input logic we,
                      input logic [1:0] ws, input logic [1:0] wd, input logic [1:0] rs);
    logic       exp_tick;
    logic [1:0] exp_rd, sel, req_code;
    mode_i = md; wr_en_i = we; wr_sel_i = ws; wr_data_i = wd; rd_sel_i = rs;
    #1;
    exp_tick = (m_count == ratio_of(m_active) - 1);
    exp_rd   = (rs == 2'd3) ? 2'd0 : m_regs[rs];
    check(tick_o == exp_tick, req, tick_o, exp_tick);
    check(rd_data_o == exp_rd, req, rd_data_o, exp_rd);
    sel      = (md != 2'd3) ? md : m_last;
    req_code = m_regs[sel];
    @(posedge clk);
    if (md != 2'd3) m_last = md;
    if (exp_tick) begin m_active = req_code; m_count = 0; end
    else m_count++;
    if (we && ws != 2'd3) m_regs[ws] = wd;
    @(negedge clk);
  endtask

  task automatic idle(input string req, input logic [1:0] md, input int n);
    for (int i = 0; i < n; i++) step(req, md, 1'b0, 2'd0, 2'd0, 2'(i % 4));
  endtask

  task automatic wr(input string req, input logic [1:0] md, input logic [1:0] ws,
                    input logic [1:0] wd);
    step(req, md, 1'b1, ws, wd, ws);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; mode_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0; rd_sel_i = 0;
    for (int i = 0; i < 3; i++) m_regs[i] = 2'd0;
    m_last = 2'd0; m_active = 2'd0; m_count = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state, ratio 1 pulses at once, all registers read 0
    idle("R8", 2'd0, 4);
    // R5: divide-by-1 pulses every cycle
    idle("R5", 2'd1, 6);
    // R1: each ratio on the run register
    wr("R1", 2'd0, 2'd0, 2'd1); idle("R1", 2'd0, 10);
    wr("R1", 2'd0, 2'd0, 2'd2); idle("R1", 2'd0, 30);
    wr("R1", 2'd0, 2'd0, 2'd3); idle("R1", 2'd0, 80);
    // R3: readback of every register
    wr("R3", 2'd0, 2'd1, 2'd2); wr("R3", 2'd0, 2'd2, 2'd1);
    idle("R3", 2'd0, 4);
    // R4: select 3 writes nothing, read of 3 is 0
    wr("R4", 2'd0, 2'd3, 2'd0); wr("R4", 2'd0, 2'd3, 2'd3);
    idle("R4", 2'd0, 4);
    // R2: switching the power state picks sleep / deep-sleep registers
    idle("R2", 2'd1, 40); idle("R2", 2'd2, 20);
    // R7: invalid state holds the last valid selection
    idle("R7", 2'd3, 20); idle("R7", 2'd1, 3); idle("R7", 2'd3, 30);
    // R6: rewrite and state change mid-period take effect only at a boundary
    wr("R6", 2'd0, 2'd0, 2'd3); idle("R6", 2'd0, 40);
    idle("R6", 2'd0, 5); wr("R6", 2'd0, 2'd0, 2'd0); idle("R6", 2'd2, 40);
    wr("R6", 2'd2, 2'd2, 2'd3); idle("R6", 2'd2, 3); idle("R6", 2'd0, 40);

    // Random mix over all inputs
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      md = ($urandom % 16 == 0) ? 2'($urandom) : md;
      if (i == 0) md = 2'd0;
      step("R6", 2'($urandom % 4), ($urandom % 20) == 0, 2'($urandom), 2'($urandom),
           2'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule